// File: doc/BRIEF.md
# Control-Flow Signature Checker with Call Stack

This block watches a stream of signatures that a running program sends at the start of each branch-free code block. It decides whether each signature is a legal next step. Before checking starts, a control-flow graph is written into two on-chip memories through a write port. The first memory, the vertex table, is indexed by signature. Each of its entries gives the vertex kind, a start pointer and a count. The second memory is a shared successor pool, and the pointer and count of a vertex select one contiguous list in it. The upper bits of every signature name the subroutine that the vertex belongs to.

Checking runs as a stack automaton. A call-kind signature saves the current vertex on an internal stack and becomes the new current vertex. A return-kind signature must belong to the current subroutine and must appear in the current vertex's successor list. The block then restores the saved caller vertex. An ordinary signature is accepted when it appears in the current vertex's successor list. The list is searched one entry per clock cycle. Only membership in the list is tested: the block does not judge which branch the program should have taken.

The signature input is valid/ready. `sig_ready` is low while the tables are not marked loaded, and also while a list search is in progress. A signature is taken on a rising edge where `sig_valid` and `sig_ready` are both high. The source may hold `sig_valid` high for as long as it likes, but it must keep `sig_data` stable until the signature is taken.

A flow violation latches a flag together with the first offending signature. Structural faults (stack overflow, stack underflow, unknown signature) set separate sticky bits. `err_clr` clears both kinds of error.

Top module: `cfg_flow_checker`

## Requirements
- R1: When `tbl_loaded`=0, a write with `tbl_we`=1 and `tbl_sel`=0 stores a vertex entry at `tbl_addr`. The entry fields are: bits [1:0] kind (0 unknown, 1 ordinary, 2 call, 3 return), bits [4:2] successor count, and bits [10:5] start pointer. When `tbl_loaded`=0, a write with `tbl_sel`=1 stores bits [7:0] as a successor at pool address `tbl_addr`[5:0]. While `tbl_loaded`=1, writes are ignored.
- R2: `sig_ready` is 0 while `tbl_loaded`=0. When `tbl_loaded`=1, `sig_ready` is 1 exactly when no list search is in progress.
- R3: After reset, or after `tbl_loaded` has been 0, the first accepted signature must be of kind call. It becomes the current vertex and nothing is pushed. Any other known kind raises a flow violation.
- R4: An ordinary signature is searched for in the current vertex's list, one entry per cycle. If it is taken at edge k and found at list position i, it becomes current at edge k+1+i. If it is absent, the violation is raised at edge k+count. `sig_ready` is low from edge k until the result.
- R5: A call signature, when not the first one, pushes the current vertex and becomes current. It is not checked for membership in any list.
- R6: A return signature whose upper 3 bits differ from those of the current vertex raises a flow violation at once. Otherwise it is searched for as in R4, and on a hit the saved caller vertex becomes current again.
- R7: An ordinary or return signature that arrives while the current vertex has a count of 0 raises a flow violation at the edge where it is taken.
- R8: A flow violation sets `flow_err` and stores the offending signature in `flow_err_sig`. Later violations do not overwrite it until it is cleared. The current vertex is not changed by a violation.
- R9: Structural faults set sticky bits in `fault_flags` and leave the current vertex and the stack unchanged. Bit 0 is a call arriving with 4 vertices already saved. Bit 1 is a return that is found in the list while nothing is saved. Bit 2 is a signature whose vertex kind is 0.
- R10: `err_clr` clears `flow_err`, `flow_err_sig` and `fault_flags` at the next edge. An error detected at that same edge is recorded after the clear.
- R11: Driving `tbl_loaded` to 0 abandons any search, empties the stack and returns the checker to the state of R3. Latched errors are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 selects the vertex table, 1 selects the successor pool |
| tbl_addr | input | 8 | Write address |
| tbl_wdata | input | 11 | Write data |
| tbl_loaded | input | 1 | Tables complete; enables checking |
| sig_valid | input | 1 | Signature offered |
| sig_ready | output | 1 | Checker can take a signature |
| sig_data | input | 8 | Signature; upper 3 bits name the subroutine |
| err_clr | input | 1 | Clears the flow and fault errors |
| flow_err | output | 1 | Latched flow violation |
| flow_err_sig | output | 8 | First offending signature |
| fault_flags | output | 3 | Sticky overflow, underflow and unknown-vertex bits |

## Verification
The assertions assume that `sig_data` is stable while `sig_valid` waits for `sig_ready`. They also assume that table writes happen only while `tbl_loaded` is 0, and that no vertex has a count above the count field's range. The stimulus meets these assumptions because every signature is driven through one handshake routine, which raises valid only after it has seen ready high. The complete table is also written before `tbl_loaded` is raised, apart from one deliberate write made while loaded to show that such writes are ignored. The clear check assumes that the checker is idle and that no signature is offered in the same cycle. The bench keeps to this except in the one case that tests a clear and a new error arriving together.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_STEP = 2'd1,
    K_CALL = 2'd2,
    K_RET  = 2'd3
  } vkind_e;

  localparam int F_OVF = 0;
  localparam int F_UNF = 1;
  localparam int F_UNK = 2;
  localparam int NFAULT = 3;
endpackage

// File: rtl/cfc_tables.sv
module cfc_tables #(
  parameter int SIG_W   = 8,
  parameter int SUCC_AW = 6,
  parameter int CNT_W   = 3,
  parameter int ENT_W   = 2 + CNT_W + SUCC_AW,
  parameter int DW      = ENT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [SIG_W-1:0]   wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               lock,
  input  logic [SIG_W-1:0]   ra_addr,
  output logic [1:0]         ra_kind,
  input  logic [SIG_W-1:0]   rb_addr,
  output logic [ENT_W-3:0]   rb_link,
  input  logic [SUCC_AW-1:0] rs_addr,
  output logic [SIG_W-1:0]   rs_sig
);
  localparam int NSTATE = 1 << SIG_W;
  localparam int NSUCC  = 1 << SUCC_AW;

  logic [ENT_W-1:0] ent_mem  [NSTATE];
  logic [SIG_W-1:0] succ_mem [NSUCC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTATE; i++) ent_mem[i] <= '0;
    end else if (wr_en && !lock && !wr_sel) begin
      ent_mem[wr_addr] <= wr_data[ENT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !lock && wr_sel) succ_mem[wr_addr[SUCC_AW-1:0]] <= wr_data[SIG_W-1:0];
  end

  assign ra_kind = ent_mem[ra_addr][1:0];
  assign rb_link = ent_mem[rb_addr][ENT_W-1:2];
  assign rs_sig  = succ_mem[rs_addr];
endmodule

// File: rtl/cfc_stack.sv
module cfc_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] spm1;

  assign spm1  = sp - PW'(1);
  assign top   = mem[spm1[IW-1:0]];
  assign empty = (sp == '0);
  assign full  = (sp == PW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      sp <= '0;
    end else if (push && !full) begin
      mem[sp[IW-1:0]] <= din;
      sp <= sp + PW'(1);
    end else if (pop && !empty) begin
      sp <= spm1;
    end
  end
endmodule

// File: rtl/cfc_engine.sv
module cfc_engine
  import cfc_pkg::*;
#(
  parameter int SIG_W   = 8,
  parameter int FUNC_W  = 3,
  parameter int SUCC_AW = 6,
  parameter int CNT_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loaded,
  input  logic                   sig_valid,
  input  logic [SIG_W-1:0]       sig_data,
  output logic                   sig_ready,
  input  logic                   err_clr,
  input  logic [1:0]             in_kind_raw,
  input  logic [CNT_W+SUCC_AW-1:0] cur_link,
  input  logic [SIG_W-1:0]       succ_sig,
  output logic [SIG_W-1:0]       cur,
  output logic [SUCC_AW-1:0]     succ_addr,
  output logic                   stk_push,
  output logic                   stk_pop,
  input  logic [SIG_W-1:0]       stk_top,
  input  logic                   stk_empty,
  input  logic                   stk_full,
  output logic                   flow_err,
  output logic [SIG_W-1:0]       flow_sig,
  output logic [NFAULT-1:0]      faults
);
  typedef enum logic {S_IDLE, S_SRCH} st_e;

  st_e              st;
  logic             fresh, hold_ret;
  logic [SIG_W-1:0] hold;
  logic [SUCC_AW-1:0] base;
  logic [CNT_W-1:0] cnt_r, idx;

  vkind_e             in_kind;
  logic [CNT_W-1:0]   cur_cnt;
  logic [SUCC_AW-1:0] cur_ptr;
  logic accept, hit, last, flow_set, go_srch, take_in, take_hold, take_top;
  logic [SIG_W-1:0]  flow_val;
  logic [NFAULT-1:0] fault_set;

  assign in_kind   = vkind_e'(in_kind_raw);
  assign cur_cnt   = cur_link[CNT_W-1:0];
  assign cur_ptr   = cur_link[CNT_W +: SUCC_AW];
  assign sig_ready = loaded && (st == S_IDLE);
  assign accept    = sig_valid && sig_ready;
  assign succ_addr = base + SUCC_AW'(idx);
  assign hit       = (st == S_SRCH) && loaded && (succ_sig == hold);
  assign last      = (st == S_SRCH) && loaded && (idx == cnt_r - CNT_W'(1));

  always_comb begin
    flow_set = 1'b0; flow_val = sig_data; fault_set = '0;
    go_srch = 1'b0; take_in = 1'b0; take_hold = 1'b0; take_top = 1'b0;
    stk_push = 1'b0; stk_pop = 1'b0;
    if (accept) begin
      if (in_kind == K_NONE) begin
        fault_set[F_UNK] = 1'b1;
      end else if (fresh) begin
        if (in_kind == K_CALL) take_in = 1'b1;
        else flow_set = 1'b1;
      end else if (in_kind == K_CALL) begin
        if (stk_full) fault_set[F_OVF] = 1'b1;
        else begin stk_push = 1'b1; take_in = 1'b1; end
      end else if (in_kind == K_RET &&
                   sig_data[SIG_W-1 -: FUNC_W] != cur[SIG_W-1 -: FUNC_W]) begin
        flow_set = 1'b1;
      end else if (cur_cnt == '0) begin
        flow_set = 1'b1;
      end else begin
        go_srch = 1'b1;
      end
    end
    if (hit) begin
      if (!hold_ret) take_hold = 1'b1;
      else if (stk_empty) fault_set[F_UNF] = 1'b1;
      else begin stk_pop = 1'b1; take_top = 1'b1; end
    end else if (last) begin
      flow_set = 1'b1;
      flow_val = hold;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fresh <= 1'b1; hold_ret <= 1'b0; hold <= '0;
      base <= '0; cnt_r <= '0; idx <= '0; cur <= '0;
      flow_err <= 1'b0; flow_sig <= '0; faults <= '0;
    end else begin
      if (!loaded) begin
        st <= S_IDLE;
        fresh <= 1'b1;
      end else begin
        if (go_srch) begin
          st <= S_SRCH; hold <= sig_data; hold_ret <= (in_kind == K_RET);
          base <= cur_ptr; cnt_r <= cur_cnt; idx <= '0;
        end else if (st == S_SRCH) begin
          if (hit || last) st <= S_IDLE;
          else idx <= idx + CNT_W'(1);
        end
        if (take_in) begin cur <= sig_data; fresh <= 1'b0; end
        if (take_hold) cur <= hold;
        if (take_top) cur <= stk_top;
      end
      if (err_clr) begin
        flow_err <= 1'b0;
        flow_sig <= '0;
      end
      if (flow_set && (!flow_err || err_clr)) begin
        flow_err <= 1'b1;
        flow_sig <= flow_val;
      end
      faults <= (err_clr ? '0 : faults) | fault_set;
    end
  end
endmodule

// File: rtl/cfg_flow_checker.sv
module cfg_flow_checker
  import cfc_pkg::*;
#(
  parameter int SIG_W   = 8,
  parameter int FUNC_W  = 3,
  parameter int SUCC_AW = 6,
  parameter int CNT_W   = 3,
  parameter int STK_D   = 4,
  localparam int ENT_W  = 2 + CNT_W + SUCC_AW,
  localparam int TBL_DW = (ENT_W > SIG_W) ? ENT_W : SIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [SIG_W-1:0]  tbl_addr,
  input  logic [TBL_DW-1:0] tbl_wdata,
  input  logic              tbl_loaded,
  input  logic              sig_valid,
  output logic              sig_ready,
  input  logic [SIG_W-1:0]  sig_data,
  input  logic              err_clr,
  output logic              flow_err,
  output logic [SIG_W-1:0]  flow_err_sig,
  output logic [NFAULT-1:0] fault_flags
);
  logic [1:0]             in_kind;
  logic [ENT_W-3:0]       cur_link;
  logic [SIG_W-1:0]       cur, succ_sig, stk_top;
  logic [SUCC_AW-1:0]     succ_addr;
  logic                   stk_push, stk_pop, stk_empty, stk_full;

  cfc_tables #(.SIG_W(SIG_W), .SUCC_AW(SUCC_AW), .CNT_W(CNT_W),
               .ENT_W(ENT_W), .DW(TBL_DW)) tables_i (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_sel(tbl_sel),
    .wr_addr(tbl_addr), .wr_data(tbl_wdata), .lock(tbl_loaded),
    .ra_addr(sig_data), .ra_kind(in_kind),
    .rb_addr(cur), .rb_link(cur_link),
    .rs_addr(succ_addr), .rs_sig(succ_sig)
  );

  cfc_stack #(.W(SIG_W), .DEPTH(STK_D)) stack_i (
    .clk(clk), .rst_n(rst_n), .flush(!tbl_loaded), .push(stk_push),
    .pop(stk_pop), .din(cur), .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  cfc_engine #(.SIG_W(SIG_W), .FUNC_W(FUNC_W), .SUCC_AW(SUCC_AW),
               .CNT_W(CNT_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .loaded(tbl_loaded), .sig_valid(sig_valid),
    .sig_data(sig_data), .sig_ready(sig_ready), .err_clr(err_clr),
    .in_kind_raw(in_kind), .cur_link(cur_link), .succ_sig(succ_sig),
    .cur(cur), .succ_addr(succ_addr), .stk_push(stk_push), .stk_pop(stk_pop),
    .stk_top(stk_top), .stk_empty(stk_empty), .stk_full(stk_full),
    .flow_err(flow_err), .flow_sig(flow_err_sig), .faults(fault_flags)
  );
endmodule

// File: rtl/cfc_checker_sva.sv
module cfc_checker_sva #(
  parameter int SIG_W = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tbl_loaded,
  input logic             sig_valid,
  input logic             sig_ready,
  input logic             err_clr,
  input logic             flow_err,
  input logic [SIG_W-1:0] flow_err_sig,
  input logic [2:0]       fault_flags
);
  localparam int LIM = 1 << CNT_W;
  logic [CNT_W+1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !tbl_loaded || sig_ready) low_run <= '0;
    else if (low_run <= (CNT_W+2)'(LIM)) low_run <= low_run + 1'b1;
  end

  // R2
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_loaded |-> !sig_ready);

  // R4
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= (CNT_W+2)'(LIM));

  // R8
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_err && !err_clr |=> flow_err && $stable(flow_err_sig));

  // R9
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && sig_ready && !sig_valid |=> !flow_err && (fault_flags == 3'b000));
endmodule

bind cfg_flow_checker cfc_checker_sva #(.SIG_W(SIG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tbl_loaded(tbl_loaded), .sig_valid(sig_valid),
  .sig_ready(sig_ready), .err_clr(err_clr), .flow_err(flow_err),
  .flow_err_sig(flow_err_sig), .fault_flags(fault_flags)
);

// File: tb/cfg_flow_checker_tb_top.sv
module cfg_flow_checker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tbl_we = 0, tbl_sel = 0, tbl_loaded = 0, sig_valid = 0, err_clr = 0;
  logic [7:0]  tbl_addr = 0, sig_data = 0;
  logic [10:0] tbl_wdata = 0;
  logic sig_ready, flow_err;
  logic [7:0] flow_err_sig;
  logic [2:0] fault_flags;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R2";

  cfg_flow_checker dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_loaded(tbl_loaded),
    .sig_valid(sig_valid), .sig_ready(sig_ready), .sig_data(sig_data),
    .err_clr(err_clr), .flow_err(flow_err), .flow_err_sig(flow_err_sig),
    .fault_flags(fault_flags)
  );

  always #10 clk = ~clk;

  // behavioural reference model
  int m_kind[256], m_cnt[256], m_ptr[256], m_succ[64];
  int m_stk[$];
  bit m_fresh, m_busy, m_ok, m_ret, m_ferr;
  int m_wait, m_cur, m_pend, m_fsig, m_faults;

  always @(posedge clk) begin
    bit nf; int ns, nfl, s, k, pos;
    nf = 0; ns = 0; nfl = 0;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_kind[i] = 0;
      m_stk.delete(); m_fresh = 1; m_busy = 0; m_cur = 0;
      m_ferr = 0; m_fsig = 0; m_faults = 0;
    end else begin
      if (tbl_we && !tbl_loaded) begin
        if (!tbl_sel) begin
          m_kind[tbl_addr] = tbl_wdata[1:0];
          m_cnt[tbl_addr]  = tbl_wdata[4:2];
          m_ptr[tbl_addr]  = tbl_wdata[10:5];
        end else m_succ[tbl_addr % 64] = tbl_wdata[7:0];
      end
      if (!tbl_loaded) begin
        m_busy = 0; m_fresh = 1; m_stk.delete();
      end else if (m_busy) begin
        m_wait--;
        if (m_wait == 0) begin
          m_busy = 0;
          if (!m_ok) begin nf = 1; ns = m_pend; end
          else if (!m_ret) m_cur = m_pend;
          else if (m_stk.size() == 0) nfl |= 2;
          else m_cur = m_stk.pop_back();
        end
      end else if (sig_valid) begin
        s = sig_data; k = m_kind[s];
        if (k == 0) nfl |= 4;
        else if (m_fresh) begin
          if (k == 2) begin m_cur = s; m_fresh = 0; end
          else begin nf = 1; ns = s; end
        end else if (k == 2) begin
          if (m_stk.size() == 4) nfl |= 1;
          else begin m_stk.push_back(m_cur); m_cur = s; end
        end else if (k == 3 && (s >> 5) != (m_cur >> 5)) begin nf = 1; ns = s; end
        else if (m_cnt[m_cur] == 0) begin nf = 1; ns = s; end
        else begin
          pos = -1;
          for (int i = 0; i < m_cnt[m_cur]; i++)
            if (pos < 0 && m_succ[(m_ptr[m_cur] + i) % 64] == s) pos = i;
          m_busy = 1; m_pend = s; m_ret = (k == 3); m_ok = (pos >= 0);
          m_wait = m_ok ? pos + 1 : m_cnt[m_cur];
        end
      end
      if (err_clr) begin m_ferr = 0; m_fsig = 0; m_faults = 0; end
      if (nf && !m_ferr) begin m_ferr = 1; m_fsig = ns; end
      m_faults |= nfl;
    end
  end

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("sig_ready", sig_ready, tbl_loaded && !m_busy);
      cmp("flow_err", flow_err, m_ferr);
      cmp("flow_err_sig", flow_err_sig, m_fsig);
      cmp("fault_flags", fault_flags, m_faults);
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic wr(bit sel, int a, int d);
    tbl_we = 1; tbl_sel = sel; tbl_addr = 8'(a); tbl_wdata = 11'(d);
    step(); tbl_we = 0;
  endtask

  int nxt = 0;
  task automatic defv(int s, int k, int n, int a = 0, int b = 0, int c = 0);
    int l[3];
    l[0] = a; l[1] = b; l[2] = c;
    wr(0, s, (nxt << 5) | (n << 2) | k);
    for (int i = 0; i < n; i++) wr(1, nxt + i, l[i]);
    nxt += n;
  endtask

  task automatic send(int s);
    while (!sig_ready) step();
    sig_valid = 1; sig_data = 8'(s);
    step(); sig_valid = 0;
  endtask

  task automatic settle(); while (!sig_ready) step(); endtask
  task automatic clr(); err_clr = 1; step(); err_clr = 0; endtask

  task automatic expect_eq(string req, string what, int act, int exp);
    cur_req = req; cmp(what, act, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int lows;
    repeat (3) step();
    rst_n = 1; step();
    expect_eq("R2", "ready after reset", sig_ready, 0);
    expect_eq("R8", "flow_err after reset", flow_err, 0);
    cur_req = "R1";
    defv('h01, 2, 1, 'h02);
    defv('h02, 1, 2, 'h03, 'h04);
    defv('h03, 1, 1, 'h05);
    defv('h04, 1, 2, 'h05, 'h02);
    defv('h05, 1, 3, 'h02, 'h06, 'h07);
    defv('h06, 3, 0);
    defv('h07, 1, 0);
    defv('h21, 2, 1, 'h22);
    defv('h22, 1, 2, 'h23, 'h24);
    defv('h23, 3, 0);
    defv('h24, 1, 1, 'h23);
    tbl_loaded = 1; step();
    expect_eq("R2", "ready when loaded", sig_ready, 1);
    wr(0, 'h02, 0);  // R1: ignored while loaded

    cur_req = "R3"; send('h02); settle();
    expect_eq("R3", "first non-call sig", flow_err_sig, 'h02);
    clr();
    expect_eq("R10", "cleared flow_err", flow_err, 0);

    cur_req = "R4";
    send('h01); send('h02); send('h04); send('h02); send('h03); send('h05); settle();
    expect_eq("R4", "legal path no error", flow_err, 0);
    expect_eq("R1", "locked write ignored", fault_flags, 0);

    cur_req = "R8"; send('h03); settle(); send('h04); settle();
    expect_eq("R8", "first offender kept", flow_err_sig, 'h03);
    clr(); send('h02); settle();
    expect_eq("R8", "state unchanged after violation", flow_err, 0);
    send('h03); send('h05); settle();

    cur_req = "R4"; send('h07); lows = 0;
    while (!sig_ready) begin lows++; step(); end
    expect_eq("R4", "ready low for hit at pos 2", lows, 3);
    cur_req = "R7"; send('h02);
    expect_eq("R7", "empty list immediate violation", flow_err_sig, 'h02);
    clr();

    cur_req = "R11"; tbl_loaded = 0; step();
    expect_eq("R2", "ready drops when unloaded", sig_ready, 0);
    tbl_loaded = 1; send('h02); settle();
    expect_eq("R11", "fresh after unload", flow_err, 1);
    clr(); send('h01); send('h02); send('h03); send('h05); settle();

    cur_req = "R5"; send('h21); send('h22); send('h24);
    cur_req = "R6"; send('h23); settle(); send('h02); settle();
    expect_eq("R6", "return to caller", flow_err, 0);
    send('h03); send('h05);
    cur_req = "R9"; send('h06); settle();
    expect_eq("R9", "underflow bit", fault_flags, 2);
    expect_eq("R9", "underflow no flow error", flow_err, 0);
    clr();

    cur_req = "R6"; send('h21); send('h22); send('h06);
    expect_eq("R6", "foreign return", flow_err_sig, 'h06);
    clr();
    cur_req = "R9"; send('h99);
    expect_eq("R9", "unknown bit", fault_flags, 4);
    clr();
    cur_req = "R5"; send('h21); send('h21); send('h21);
    expect_eq("R5", "calls accepted", fault_flags, 0);
    cur_req = "R9"; send('h21);
    expect_eq("R9", "overflow bit", fault_flags, 1);

    cur_req = "R10";
    while (!sig_ready) step();
    err_clr = 1; sig_valid = 1; sig_data = 8'h99; step();
    err_clr = 0; sig_valid = 0;
    expect_eq("R10", "clear then new fault", fault_flags, 4);
    repeat (3) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule